// File: doc/BRIEF.md
# Network Controller Interrupt Status and Control Register

This block collects the interrupt-causing events of a bus-mastering network controller and presents them to the host as one status register. Single-cycle event pulses from the receive, transmit and initialization logic, plus a missed-frame pulse, are caught in sticky status bits that the host clears by writing ones. A built-in monitor watches the controller's bus request and grant. When the grant does not come back within a programmable number of 0.1 µs ticks, the monitor raises a memory-error event.

Each latched source has its own mask bit in a separate control register. The unmasked sources are OR-ed into a read-only summary flag. The interrupt output is that flag gated by a global enable bit. An error summary bit reports a missed frame or a memory error whatever the masks and the enable say. A stop request and a soft reset both wipe the status and the enable. The soft reset also returns the control and timeout registers to their defaults.

Top module: `nic_irq_csr`

## Requirements
- R1: An event pulse sets its status bit (address 0) on the next clock edge: initialization done at bit 8, transmit done at bit 9, receive done at bit 10, memory error at bit 11, missed frame at bit 12. The bit stays set until it is cleared.
- R2: A write to address 0 clears every status bit in 12..8 whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R3: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R4: The summary flag (address 0, bit 7, read-only) is 1 exactly when some status bit in 12..8 is set while its mask bit is 0. The mask bits sit at address 1, bits 12..8, in the same order as the status bits.
- R5: The enable bit (address 0, bit 6) takes the value written to bit 6 on every write to address 0. The `irq` output is 1 only while both the enable bit and the summary flag are 1.
- R6: The error bit (address 0, bit 15) and the `err` output are 1 whenever the missed-frame or the memory-error status bit is set. Masks and the enable do not affect them.
- R7: `ev_rx_last` always sets the receive-done bit. `ev_rx_first` sets it only while the early-receive control bit (address 1, bit 5) is 1.
- R8: A cycle with `stop` or `soft_rst` high clears all status bits and the enable bit, and events arriving in that cycle are lost. `soft_rst` also clears the mask bits and the early-receive bit, and it reloads the timeout register (address 2) with 512.
- R9: A rising `bus_hold` with `bus_hlda` low starts a timeout of L ticks, where L is the address-2 value and one tick is TICK_DIV clocks. The memory-error bit becomes visible exactly L·TICK_DIV+1 edges after the edge that saw the rise. The timeout fires once per request, and a new rise restarts it.
- R10: If `bus_hlda` rises or `bus_hold` falls before the timeout expires, the memory-error bit is not set.
- R11: After hard reset, the status register reads 0, and `irq` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| stop | input | 1 | Stop request; wipes status and enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 status, 1 control, 2 timeout |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| ev_miss | input | 1 | Missed-frame event pulse |
| ev_rx_last | input | 1 | Receive last-descriptor event pulse |
| ev_rx_first | input | 1 | Receive first-descriptor event pulse |
| ev_tx_done | input | 1 | Transmit done event pulse |
| ev_init_done | input | 1 | Initialization done event pulse |
| bus_hold | input | 1 | Bus request from the DMA side |
| bus_hlda | input | 1 | Bus grant |
| irq | output | 1 | Interrupt output, active high |
| err | output | 1 | Error summary |

## Verification
The status path is driven with lone pulses per source, a zero write next to a one write, and an event colliding with its own clear. These tell a correct W1C latch apart from one that clears on any write or lets the clear win. The summary flag is driven with the same latched source masked and then unmasked, and with the enable both off and on, which separates mask gating from enable gating. The timeout monitor is tried with a request that is never granted, one that is dropped and raised again, one that is granted late but in time, and one that is withdrawn. Edge-exact sampling of the memory-error bit exposes off-by-one tick counts and a missing restart.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
   localparam int NUM_SRC   = 5;
   localparam int SRC_IDON  = 0;
   localparam int SRC_TINT  = 1;
   localparam int SRC_RINT  = 2;
   localparam int SRC_MERR  = 3;
   localparam int SRC_MISS  = 4;
   localparam int SRC_LSB   = 8;
   localparam int FLAG_POS  = 7;
   localparam int EN_POS    = 6;
   localparam int EARLY_POS = 5;
   localparam int ERR_POS   = 15;
   localparam int MIN_REG_W = 16;

   typedef enum logic [1:0] {
      ADDR_STAT = 2'd0,
      ADDR_CTRL = 2'd1,
      ADDR_TMO  = 2'd2
   } reg_addr_e;
endpackage

// File: rtl/nic_irq_evt_bit.sv
module nic_irq_evt_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic wipe,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (wipe)  q <= 1'b0;
      else if (set)   q <= 1'b1;
      else if (clr)   q <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !wipe) |=> q); // R3
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set && !wipe) |=> !q); // R2
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr && !wipe) |=> q); // R1
endmodule

// File: rtl/nic_irq_bus_wdog.sv
module nic_irq_bus_wdog #(
   parameter int TO_W     = 16,
   parameter int TICK_DIV = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sclr,
   input  logic            hold,
   input  logic            hlda,
   input  logic [TO_W-1:0] limit,
   output logic            fire
);
   localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic            hold_q;
   logic            armed;
   logic [TO_W-1:0] cnt;
   logic            tick;
   logic            start;

   assign start = hold && !hold_q && !hlda;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("nic_irq_bus_wdog: TICK_DIV must be at least 1");
      end
      if (TO_W < 2) begin : g_bad_w
         $error("nic_irq_bus_wdog: TO_W must be at least 2");
      end
      if (TICK_DIV == 1) begin : g_tick_every
         assign tick = 1'b1;
      end else begin : g_tick_div
         logic [PRE_W-1:0] pre;
         assign tick = (pre == PRE_W'(TICK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         pre <= '0;
            else if (sclr || start || !armed)   pre <= '0;
            else if (tick)                      pre <= '0;
            else                                pre <= pre + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         armed  <= 1'b0;
         cnt    <= '0;
         fire   <= 1'b0;
      end else begin
         hold_q <= hold;
         fire   <= 1'b0;
         if (sclr) begin
            armed <= 1'b0;
            cnt   <= '0;
         end else if (start) begin
            armed <= 1'b1;
            cnt   <= limit;
         end else if (armed) begin
            if (!hold || hlda) begin
               armed <= 1'b0;
            end else if (tick) begin
               if (cnt <= TO_W'(1)) begin
                  fire  <= 1'b1;
                  armed <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         end
      end
   end

   AST_FIRE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(hold && !hlda)); // R9
   AST_FIRE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire); // R9
   AST_GRANT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |=> !fire); // R10
   AST_DROP_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> !fire); // R10
endmodule

// File: rtl/nic_irq_csr.sv
module nic_irq_csr #(
   parameter int REG_W     = 16,
   parameter int TO_W      = 16,
   parameter int TO_RESET  = 512,
   parameter int TICK_DIV  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             stop,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [REG_W-1:0] rd_data,
   input  logic             ev_miss,
   input  logic             ev_rx_last,
   input  logic             ev_rx_first,
   input  logic             ev_tx_done,
   input  logic             ev_init_done,
   input  logic             bus_hold,
   input  logic             bus_hlda,
   output logic             irq,
   output logic             err
);
   import nic_irq_pkg::*;

   localparam logic [TO_W-1:0] TMO_DEF = TO_W'(TO_RESET);

   generate
      if (REG_W < MIN_REG_W) begin : g_bad_reg_w
         $error("nic_irq_csr: REG_W too narrow for the field layout");
      end
      if (TO_W > REG_W) begin : g_bad_to_w
         $error("nic_irq_csr: TO_W must fit in REG_W");
      end
   endgenerate

   logic               wipe;
   logic               wr_stat;
   logic               wr_ctrl;
   logic               wr_tmo;
   logic [NUM_SRC-1:0] src_set;
   logic [NUM_SRC-1:0] src_clr;
   logic [NUM_SRC-1:0] stat;
   logic [NUM_SRC-1:0] mask;
   logic               early;
   logic               en_q;
   logic [TO_W-1:0]    tmo;
   logic               wd_fire;
   logic               flag;

   assign wipe    = stop || soft_rst;
   assign wr_stat = wr_en && (wr_addr == ADDR_STAT);
   assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_tmo  = wr_en && (wr_addr == ADDR_TMO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask  <= '0;
         early <= 1'b0;
         tmo   <= TMO_DEF;
      end else if (soft_rst) begin
         mask  <= '0;
         early <= 1'b0;
         tmo   <= TMO_DEF;
      end else begin
         if (wr_ctrl) begin
            mask  <= wr_data[SRC_LSB +: NUM_SRC];
            early <= wr_data[EARLY_POS];
         end
         if (wr_tmo) tmo <= wr_data[TO_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (wipe)    en_q <= 1'b0;
      else if (wr_stat) en_q <= wr_data[EN_POS];
   end

   nic_irq_bus_wdog #(
      .TO_W     (TO_W),
      .TICK_DIV (TICK_DIV)
   ) u_wdog (
      .clk   (clk),
      .rst_n (rst_n),
      .sclr  (soft_rst),
      .hold  (bus_hold),
      .hlda  (bus_hlda),
      .limit (tmo),
      .fire  (wd_fire)
   );

   always_comb begin
      src_set           = '0;
      src_set[SRC_IDON] = ev_init_done;
      src_set[SRC_TINT] = ev_tx_done;
      src_set[SRC_RINT] = ev_rx_last || (early && ev_rx_first);
      src_set[SRC_MERR] = wd_fire;
      src_set[SRC_MISS] = ev_miss;
   end

   assign src_clr = wr_stat ? wr_data[SRC_LSB +: NUM_SRC] : '0;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         nic_irq_evt_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .wipe  (wipe),
            .set   (src_set[g]),
            .clr   (src_clr[g]),
            .q     (stat[g])
         );
      end
   endgenerate

   assign flag = |(stat & ~mask);
   assign irq  = en_q && flag;
   assign err  = stat[SRC_MISS] || stat[SRC_MERR];

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_STAT: begin
            rd_data[ERR_POS]              = err;
            rd_data[SRC_LSB +: NUM_SRC]   = stat;
            rd_data[FLAG_POS]             = flag;
            rd_data[EN_POS]               = en_q;
         end
         ADDR_CTRL: begin
            rd_data[SRC_LSB +: NUM_SRC]   = mask;
            rd_data[EARLY_POS]            = early;
         end
         ADDR_TMO:  rd_data[TO_W-1:0]     = tmo;
         default:   rd_data               = '0;
      endcase
   end

   AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (stat == '0 && !en_q && !irq)); // R8
   AST_MISS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_miss && !wipe) |=> err); // R6
   AST_MISS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_miss && !wipe) |=> stat[SRC_MISS]); // R1
   AST_EARLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!early && ev_rx_first && !ev_rx_last && !stat[SRC_RINT]) |=> !stat[SRC_RINT]); // R7
   AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !wr_data[EN_POS]) |=> !irq); // R5
endmodule

// File: tb/nic_irq_csr_tb.sv
module nic_irq_csr_tb;
   localparam int TDIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0, stop = 1'b0, wr_en = 1'b0;
   logic [1:0]  wr_addr = '0, rd_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        ev_miss = 0, ev_rx_last = 0, ev_rx_first = 0, ev_tx_done = 0, ev_init_done = 0;
   logic        bus_hold = 0, bus_hlda = 0;
   logic        irq, err;

   always #4 clk = ~clk;

   nic_irq_csr #(.TICK_DIV(TDIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ev_miss(ev_miss), .ev_rx_last(ev_rx_last), .ev_rx_first(ev_rx_first),
      .ev_tx_done(ev_tx_done), .ev_init_done(ev_init_done),
      .bus_hold(bus_hold), .bus_hlda(bus_hlda), .irq(irq), .err(err)
   );

   typedef struct {
      logic [15:0] st;
      logic        irq;
      logic        err;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 0;

   // model state, derived from the requirements
   logic [4:0] m_stat = '0, m_mask = '0;
   logic       m_en = 0, m_early = 0;

   function automatic exp_t model_exp(string tag);
      exp_t e;
      logic flag, er;
      flag = |(m_stat & ~m_mask);
      er   = m_stat[4] | m_stat[3];
      e.st  = {er, 2'b00, m_stat, flag, m_en, 6'b0};
      e.irq = m_en & flag;
      e.err = er;
      e.tag = tag;
      return e;
   endfunction

   // ev: [0] init, [1] tx, [2] rx_last, [4] miss
   task automatic step(input logic w, input logic [1:0] a, input logic [15:0] d,
                       input logic [4:0] ev, input logic rxf, input logic stp,
                       input logic sr, input logic mset, input string tag);
      logic [4:0] setv, clrv;
      wr_en = w; wr_addr = a; wr_data = d;
      ev_init_done = ev[0]; ev_tx_done = ev[1]; ev_rx_last = ev[2];
      ev_miss = ev[4]; ev_rx_first = rxf; stop = stp; soft_rst = sr;
      setv = {ev[4], mset, ev[2] | (m_early & rxf), ev[1], ev[0]};
      clrv = (w && a == 2'd0) ? d[12:8] : 5'b0;
      if (sr) begin
         m_stat = '0; m_en = 0; m_mask = '0; m_early = 0;
      end else begin
         if (stp) begin
            m_stat = '0; m_en = 0;
         end else begin
            m_stat = (m_stat & ~clrv) | setv;
            if (w && a == 2'd0) m_en = d[6];
         end
         if (w && a == 2'd1) begin
            m_mask = d[12:8]; m_early = d[5];
         end
      end
      @(posedge clk); #1;
      wr_en = 0; ev_init_done = 0; ev_tx_done = 0; ev_rx_last = 0;
      ev_miss = 0; ev_rx_first = 0; stop = 0; soft_rst = 0;
      exp_q.push_back(model_exp(tag));
      @(negedge clk);
   endtask

   task automatic idle(input string tag, input logic mset = 1'b0);
      step(0, 2'd0, 16'h0, 5'b0, 0, 0, 0, mset, tag);
   endtask

   // monitor: compare produced status against queued expectations
   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (rd_data !== e.st || irq !== e.irq || err !== e.err) begin
               n_err++;
               $display("FAIL %s: status=%h irq=%b err=%b expected status=%h irq=%b err=%b",
                        e.tag, rd_data, irq, err, e.st, e.irq, e.err);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle("R11 reset state");
      // R1 latching per source
      step(0, 0, 16'h0, 5'b00001, 0, 0, 0, 0, "R1 init done sets bit 8");
      step(0, 0, 16'h0, 5'b00010, 0, 0, 0, 0, "R1 tx done sets bit 9");
      step(0, 0, 16'h0, 5'b10000, 0, 0, 0, 0, "R6 missed frame sets err");
      idle("R5 irq low while enable off");
      step(1, 0, 16'h0040, 5'b0, 0, 0, 0, 0, "R5 enable raises irq");
      step(1, 0, 16'h0040, 5'b0, 0, 0, 0, 0, "R2 zero write keeps bits");
      step(1, 0, 16'h0240, 5'b0, 0, 0, 0, 0, "R2 clear tx bit");
      step(1, 0, 16'h0140, 5'b00001, 0, 0, 0, 0, "R3 set beats clear");
      step(1, 0, 16'h1040, 5'b0, 0, 0, 0, 0, "R6 err drops after miss clear");
      step(1, 1, 16'h0100, 5'b0, 0, 0, 0, 0, "R4 masked source leaves flag low");
      step(0, 0, 16'h0, 5'b00010, 0, 0, 0, 0, "R4 unmasked source raises flag");
      step(1, 0, 16'h0340, 5'b0, 0, 0, 0, 0, "R4 flag self clears");
      step(0, 0, 16'h0, 5'b0, 1, 0, 0, 0, "R7 first ignored without early");
      step(0, 0, 16'h0, 5'b00100, 0, 0, 0, 0, "R7 last sets receive bit");
      step(1, 0, 16'h0440, 5'b0, 0, 0, 0, 0, "R7 receive bit cleared");
      step(1, 1, 16'h0020, 5'b0, 0, 0, 0, 0, "R7 early enabled");
      step(0, 0, 16'h0, 5'b0, 1, 0, 0, 0, "R7 first sets with early");
      step(0, 0, 16'h0, 5'b00010, 0, 1, 0, 0, "R8 stop wipes status and enable");
      // soft reset
      step(1, 1, 16'h1f20, 5'b0, 0, 0, 0, 0, "R8 mask all");
      step(1, 0, 16'h0040, 5'b10000, 0, 0, 0, 0, "R6 err with masks set");
      step(0, 0, 16'h0, 5'b0, 0, 0, 1, 0, "R8 soft reset wipes");
      step(0, 0, 16'h0, 5'b0, 1, 0, 0, 0, "R8 soft reset drops early");
      step(1, 0, 16'h0440, 5'b0, 0, 0, 0, 0, "R8 clear and enable");
      // bus timeout: limit 3 ticks of TDIV clocks
      step(1, 2, 16'd3, 5'b0, 0, 0, 0, 0, "R9 load limit");
      bus_hold = 1;
      for (int k = 1; k <= 13; k++) idle("R9 no early timeout");
      idle("R9 timeout fires on exact edge", 1'b1);
      step(1, 0, 16'h0840, 5'b0, 0, 0, 0, 0, "R9 clear memory error");
      for (int k = 0; k < 20; k++) idle("R9 single shot per request");
      bus_hold = 0;
      idle("R9 release");
      // restart on a new rise
      bus_hold = 1;
      for (int k = 0; k < 8; k++) idle("R9 partial wait");
      bus_hold = 0;
      idle("R10 drop before timeout");
      bus_hold = 1;
      for (int k = 1; k <= 13; k++) idle("R9 restart counts anew");
      idle("R9 restarted timeout fires", 1'b1);
      step(1, 0, 16'h0840, 5'b0, 0, 0, 0, 0, "R9 clear again");
      bus_hold = 0;
      idle("R10 idle");
      // grant in time
      bus_hold = 1;
      for (int k = 0; k < 5; k++) idle("R10 waiting for grant");
      bus_hlda = 1;
      for (int k = 0; k < 20; k++) idle("R10 grant cancels timeout");
      bus_hold = 0; bus_hlda = 0;
      idle("R10 grant released");
      // withdrawn request
      bus_hold = 1;
      for (int k = 0; k < 5; k++) idle("R10 request pending");
      bus_hold = 0;
      for (int k = 0; k < 20; k++) idle("R10 withdrawn request stays quiet");
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule